// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block is the external bus interface of a 16-bit processor. One internal request carries an address, write data, a read/write flag, a memory/I-O flag, a data/instruction flag and a lock flag. Each request becomes one transaction on a single 16-bit bus that carries the address first and the data after it. The address phase is flagged by an address strobe and can be stretched by an address-ready input. The data phase is flagged by a data strobe and can be stretched by a data-ready input.

Before a transaction starts, the controller competes for the bus. It raises a bus request, and it waits for a grant while no other master holds the bus busy or locked. During its own transaction it drives its busy output. A locked transaction keeps ownership, so the next transaction can start without a new arbitration. When the transaction ends, the requester receives a one-clock done pulse together with the captured read data. The cycle-type status outputs hold steady across the whole transaction.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: After reset `reqReady` is 1. `addrStb`, `dataStb`, `busOe`, `busReq`, `busBusyOut`, `busLockOut` and `rspDone` are all 0.
- R2: An accepted request without held ownership first enters arbitration. In arbitration `busReq` is 1. Arbitration is left only after a clock where `busGnt`=1, `busBusyIn`=0 and `busLockIn`=0 together. A grant seen while `busBusyIn` or `busLockIn` is 1 adds one arbitration clock.
- R3: A transaction with no wait states takes 4 clocks. `addrStb` is 1 in clocks 1-2 and `dataStb` is 1 in clocks 3-4. The two strobes are never 1 together.
- R4: In clocks 1-2 `busOe`=1 and `busOut` is the request address. In clocks 3-4 a write has `busOe`=1 and `busOut` equal to the write data. A read has `busOe`=0 in clocks 3-4.
- R5: From acceptance to completion, `stIo` equals the I/O flag, `stWrite` the write flag and `stInstr` the instruction flag of the request (1 = I/O, write, instruction fetch). These outputs do not change during the transaction.
- R6: Each clock edge in the second address clock where `addrRdy`=0 repeats that clock, which adds one address wait clock.
- R7: Each clock edge in the second data clock where `dataRdy`=0 repeats that clock, for reads and writes alike.
- R8: `busIn` is captured on the edge that ends the data phase. In the next clock `rspDone`=1 for exactly one clock and `rspRdata` holds the captured value.
- R9: `busBusyOut` is 1 in exactly the address and data clocks of the controller's own transaction.
- R10: A transaction with `reqLock`=1 drives `busLockOut`=1 and keeps it 1 after completion. The next request then goes straight to the address phase with no `busReq`. A later transaction with `reqLock`=0 releases the lock when it completes.
- R11: `reqReady` is 1 only when idle. A request presented while a transaction is in progress is ignored and does not alter its address, data or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Internal request present |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 16 | Request write data |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory |
| reqInstr | input | 1 | 1 = instruction fetch, 0 = data |
| reqLock | input | 1 | Keep bus ownership after this transaction |
| reqReady | output | 1 | Idle, request accepted this clock |
| rspDone | output | 1 | Transaction complete pulse |
| rspRdata | output | 16 | Captured read data |
| busOut | output | 16 | Multiplexed address/data out |
| busOe | output | 1 | Output enable for the bus pads |
| busIn | input | 16 | Multiplexed bus in |
| addrStb | output | 1 | Address phase strobe |
| dataStb | output | 1 | Data phase strobe |
| addrRdy | input | 1 | Address phase ready |
| dataRdy | input | 1 | Data phase ready |
| stIo | output | 1 | Status: I/O cycle |
| stWrite | output | 1 | Status: write cycle |
| stInstr | output | 1 | Status: instruction cycle |
| busReq | output | 1 | Bus request to arbiter |
| busGnt | input | 1 | Bus grant from arbiter |
| busBusyIn | input | 1 | Another master holds the bus |
| busBusyOut | output | 1 | This controller holds the bus |
| busLockIn | input | 1 | Another master has locked the bus |
| busLockOut | output | 1 | This controller has locked the bus |

## Verification
Two coincidences are tested. The first is a grant arriving in the same clock as another master's busy or lock. The bench holds the grant high during arbitration and raises busy and lock in alternate clocks, so the wait should be exactly one clock longer for each blocked grant. The second is a new request arriving in the first clock of an active transaction. The bench presents a request with an inverted address and flipped direction there. It then requires that the address, write data and status seen in the following phases still belong to the original request.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR1,
    ST_ADDR2,
    ST_DATA1,
    ST_DATA2
  } cycState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic drvAddr;  // address clocks
    logic drvData;  // data clocks
    logic capture;  // sample busIn at end of data phase
  } dpCtl_t;

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqLock,
  input  logic   busGnt,
  input  logic   busBusyIn,
  input  logic   busLockIn,
  input  logic   addrRdy,
  input  logic   dataRdy,
  output logic   reqReady,
  output logic   busReq,
  output logic   busBusyOut,
  output logic   busLockOut,
  output logic   addrStb,
  output logic   dataStb,
  output logic   rspDone,
  output dpCtl_t ctl
);

  cycState_e stateQ, stateD;
  logic      lockHeldQ;
  logic      curLockQ;
  logic      doneQ;
  logic      busFree;
  logic      finish;
  logic      inCycle;

  assign busFree = busGnt && !busBusyIn && !busLockIn;
  assign finish  = (stateQ == ST_DATA2) && dataRdy;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (reqValid) stateD = lockHeldQ ? ST_ADDR1 : ST_ARB;
      ST_ARB:   if (busFree) stateD = ST_ADDR1;
      ST_ADDR1: stateD = ST_ADDR2;
      ST_ADDR2: if (addrRdy) stateD = ST_DATA1;
      ST_DATA1: stateD = ST_DATA2;
      ST_DATA2: if (dataRdy) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      lockHeldQ <= 1'b0;
      curLockQ  <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= finish;
      if (stateQ == ST_IDLE && reqValid) curLockQ <= reqLock;
      if (finish) lockHeldQ <= curLockQ;
    end
  end

  always_comb begin
    ctl.load    = (stateQ == ST_IDLE) && reqValid;
    ctl.drvAddr = (stateQ == ST_ADDR1) || (stateQ == ST_ADDR2);
    ctl.drvData = (stateQ == ST_DATA1) || (stateQ == ST_DATA2);
    ctl.capture = finish;
  end

  assign inCycle    = ctl.drvAddr || ctl.drvData;
  assign reqReady   = (stateQ == ST_IDLE);
  assign busReq     = (stateQ == ST_ARB);
  assign busBusyOut = inCycle;
  assign busLockOut = lockHeldQ || (inCycle && curLockQ);
  assign addrStb    = ctl.drvAddr;
  assign dataStb    = ctl.drvData;
  assign rspDone    = doneQ;

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(addrStb && dataStb)); // R3
  AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR1) |=> addrStb && !dataStb); // R3
  AST_ARB_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busFree) |=> busReq && !busBusyOut); // R2
  AST_ADDR_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ADDR2 && !addrRdy) |=> addrStb && !dataStb); // R6
  AST_DATA_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DATA2 && !dataRdy) |=> dataStb && !rspDone); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R8
  AST_BUSY_OWN: assert property (@(posedge clk) disable iff (!rstN)
    busBusyOut |-> !busReq && !reqReady); // R9

endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
  import mbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             reqWrite,
  input  logic             reqIo,
  input  logic             reqInstr,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic             stIo,
  output logic             stWrite,
  output logic             stInstr,
  output logic [BUS_W-1:0] rspRdata
);

  logic [BUS_W-1:0] addrQ, wdataQ, rdataQ;
  logic             writeQ, ioQ, instrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      writeQ <= 1'b0;
      ioQ    <= 1'b0;
      instrQ <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        writeQ <= reqWrite;
        ioQ    <= reqIo;
        instrQ <= reqInstr;
      end
      if (ctl.capture) rdataQ <= busIn;
    end
  end

  assign busOut   = ctl.drvData ? wdataQ : addrQ;
  assign busOe    = ctl.drvAddr || (ctl.drvData && writeQ);
  assign stIo     = ioQ;
  assign stWrite  = writeQ;
  assign stInstr  = instrQ;
  assign rspRdata = rdataQ;

  AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.drvAddr || ctl.drvData) && $past(ctl.drvAddr || ctl.drvData))
      |-> $stable({stIo, stWrite, stInstr, addrQ})); // R5
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !(ctl.drvAddr || ctl.drvData)); // R11
  AST_CAPTURE_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> ctl.drvData); // R8
  AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.drvAddr |-> busOe); // R4

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic             reqWrite,
  input  logic             reqIo,
  input  logic             reqInstr,
  input  logic             reqLock,
  output logic             reqReady,
  output logic             rspDone,
  output logic [BUS_W-1:0] rspRdata,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  input  logic [BUS_W-1:0] busIn,
  output logic             addrStb,
  output logic             dataStb,
  input  logic             addrRdy,
  input  logic             dataRdy,
  output logic             stIo,
  output logic             stWrite,
  output logic             stInstr,
  output logic             busReq,
  input  logic             busGnt,
  input  logic             busBusyIn,
  output logic             busBusyOut,
  input  logic             busLockIn,
  output logic             busLockOut
);

  dpCtl_t ctl;

  mbus_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLock    (reqLock),
    .busGnt     (busGnt),
    .busBusyIn  (busBusyIn),
    .busLockIn  (busLockIn),
    .addrRdy    (addrRdy),
    .dataRdy    (dataRdy),
    .reqReady   (reqReady),
    .busReq     (busReq),
    .busBusyOut (busBusyOut),
    .busLockOut (busLockOut),
    .addrStb    (addrStb),
    .dataStb    (dataStb),
    .rspDone    (rspDone),
    .ctl        (ctl)
  );

  mbus_dpath #(.BUS_W(BUS_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqWrite (reqWrite),
    .reqIo    (reqIo),
    .reqInstr (reqInstr),
    .busIn    (busIn),
    .busOut   (busOut),
    .busOe    (busOe),
    .stIo     (stIo),
    .stWrite  (stWrite),
    .stInstr  (stInstr),
    .rspRdata (rspRdata)
  );

endmodule

// File: tb/mbus_cycle_ctrl_tb.sv
module mbus_cycle_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0, busIn = '0;
  logic        reqWrite = 1'b0, reqIo = 1'b0, reqInstr = 1'b0, reqLock = 1'b0;
  logic        addrRdy = 1'b1, dataRdy = 1'b1;
  logic        busGnt = 1'b0, busBusyIn = 1'b0, busLockIn = 1'b0;
  logic        reqReady, rspDone, busOe, addrStb, dataStb;
  logic        stIo, stWrite, stInstr, busReq, busBusyOut, busLockOut;
  logic [15:0] rspRdata, busOut;

  int testCnt = 0;
  int failCnt = 0;

  // expectations of the transaction in flight
  logic [15:0] expAddr, expWdata, expRd;
  logic        expW, expIo, expIns, expLock, heldBefore = 1'b0;
  logic        first;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_cycle_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqWrite(reqWrite), .reqIo(reqIo),
    .reqInstr(reqInstr), .reqLock(reqLock), .reqReady(reqReady),
    .rspDone(rspDone), .rspRdata(rspRdata), .busOut(busOut), .busOe(busOe),
    .busIn(busIn), .addrStb(addrStb), .dataStb(dataStb), .addrRdy(addrRdy),
    .dataRdy(dataRdy), .stIo(stIo), .stWrite(stWrite), .stInstr(stInstr),
    .busReq(busReq), .busGnt(busGnt), .busBusyIn(busBusyIn),
    .busBusyOut(busBusyOut), .busLockIn(busLockIn), .busLockOut(busLockOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of a transaction: p 0=arb 1=addr1 2=addr2 3=data1 4=data2
  task automatic step(input int p, input logic rA, input logic rD,
                      input logic g, input logic bb, input logic bl);
    logic [10:0] act, exp;
    logic eAS, eDS;
    @(negedge clk);
    eAS = (p == 1) || (p == 2);
    eDS = (p >= 3);
    act = {addrStb, dataStb, busOe, busReq, busBusyOut, busLockOut,
           stIo, stWrite, stInstr, reqReady, rspDone};
    exp = {eAS, eDS, eAS || (eDS && expW), p == 0, p >= 1,
           heldBefore || (p >= 1 && expLock), expIo, expW, expIns, 1'b0, 1'b0};
    chk($sformatf("R2 R3 R5 R6 R7 R9 R10 R11 phase%0d outputs", p), {21'd0, act}, {21'd0, exp});
    if (eAS) chk("R4 R11 address on bus", {16'd0, busOut}, {16'd0, expAddr});
    if (eDS && expW) chk("R4 write data on bus", {16'd0, busOut}, {16'd0, expWdata});
    if (first) begin
      // request during an active transaction must be ignored (R11)
      reqValid = 1'b1; reqAddr = ~expAddr; reqWdata = ~expWdata;
      reqWrite = ~expW; reqIo = ~expIo; reqInstr = ~expIns;
      first = 1'b0;
    end else reqValid = 1'b0;
    addrRdy = rA; dataRdy = rD; busGnt = g; busBusyIn = bb; busLockIn = bl;
    busIn = (p == 4) ? expRd : 16'h0000;
  endtask

  task automatic xfer(input logic w, input logic io, input logic ins, input logic lk,
                      input int aw, input int dw, input int gw, input logic [15:0] a);
    @(negedge clk);
    chk("R11 ready when idle", {31'd0, reqReady}, 32'd1);
    expAddr = a; expWdata = a ^ 16'hC3A5; expRd = ~a ^ 16'h0F0F;
    expW = w; expIo = io; expIns = ins; expLock = lk; first = 1'b1;
    reqValid = 1'b1; reqAddr = expAddr; reqWdata = expWdata;
    reqWrite = w; reqIo = io; reqInstr = ins; reqLock = lk;
    busGnt = 1'b0;
    if (!heldBefore)
      for (int i = 0; i <= gw; i++)
        step(0, 1'b0, 1'b0, 1'b1, (i < gw) && (i % 2 == 0), (i < gw) && (i % 2 == 1));
    step(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i <= aw; i++) step(2, i == aw, 1'b0, 1'b0, 1'b0, 1'b0);
    step(3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i <= dw; i++) step(4, 1'b0, i == dw, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 done pulse", {31'd0, rspDone}, 32'd1);
    if (!w) chk("R8 read data", {16'd0, rspRdata}, {16'd0, expRd});
    chk("R9 R10 idle bus outputs",
        {27'd0, addrStb, dataStb, busOe, busBusyOut, busLockOut},
        {27'd0, 4'b0000, lk});
    heldBefore = lk; reqValid = 1'b0; dataRdy = 1'b0; reqLock = 1'b0;
    @(negedge clk);
    chk("R8 done lasts one clock", {31'd0, rspDone}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs",
        {24'd0, reqReady, addrStb, dataStb, busOe, busReq, busBusyOut, busLockOut, rspDone},
        {24'd0, 8'b1000_0000});
    for (int aw = 0; aw < 3; aw++)
      for (int dw = 0; dw < 3; dw++)
        for (int k = 0; k < 8; k++)
          xfer(k[0], k[1], k[2], 1'b0, aw, dw, (aw + dw + k) % 4,
               16'(aw * 4099 + dw * 313 + k * 37 + 16'h1200));
    // lock sequence: take lock, reuse ownership, release, arbitrate again
    xfer(1'b0, 1'b0, 1'b1, 1'b1, 0, 1, 2, 16'hBEEF);
    xfer(1'b1, 1'b1, 1'b0, 1'b1, 1, 0, 3, 16'h1357);
    xfer(1'b0, 1'b1, 1'b0, 1'b0, 0, 0, 1, 16'h2468);
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 2, 2, 3, 16'hFFFF);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule